// File: doc/BRIEF.md
# Accumulator CPU Core with Eight Operations

This block is a small multicycle processor built around one 8-bit accumulator. It reaches an external memory through a 13-bit address bus, an 8-bit bidirectional data bus and two active-high strobes, one for reads and one for writes. Each instruction is two bytes long. The processor reads both bytes, decodes a 3-bit operation code and a 13-bit operand address, and then carries out one of eight operations on the accumulator, the memory or the program counter.

Every instruction takes exactly eight clocks. The first half of that slot (phases 0 to 3) puts the program counter on the address bus. The second half (phases 4 to 7) puts the decoded operand address there. Instead of conditional branches, a skip instruction jumps over the next instruction when the accumulator is zero. A stop instruction raises the halt output and freezes the core until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, the instruction register and the accumulator, and also clears the halt state. In the first clock after `rst` falls, `rd` is 1 and `addr` is 0.
- R2: Each instruction takes 8 clocks, counted as phases 0 to 7. Phase 0 reads the byte at PC and phase 1 reads the byte at PC+1, with `rd` high in both. The first byte holds the opcode in bits 7:5 and operand bits 12:8 in bits 4:0. The second byte holds operand bits 7:0.
- R3: After any instruction other than a taken skip, a jump or a stop, the next instruction is fetched at the old PC plus 2.
- R4: The memory-reading operations are LDA (101), ADD (010), AND (011) and XOR (100). Each puts the operand on `addr` with `rd` high in phase 4 and writes the result into the accumulator. LDA loads the byte, ADD adds modulo 256, and AND and XOR combine bitwise.
- R5: STO (110) drives the accumulator onto `data` in phases 5 and 6 and raises `wr` only in phase 6, with `addr` equal to the operand. No other operation drives the bus or raises `wr`.
- R6: JMP (111) makes the next fetch address equal to the 13-bit operand.
- R7: SKZ (001) makes the next fetch address PC+4 when the accumulator is zero. Otherwise the next fetch address is PC+2.
- R8: HLT (000) raises `halt` at the end of phase 2 of that instruction. After that, `halt` stays high, `rd` and `wr` stay low and the PC holds until reset.
- R9: `rd` and `wr` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | output | 13 | Memory address: PC during phases 0-3, operand during phases 4-7 |
| data | inout | 8 | Bidirectional memory data, driven by the core only during a store |
| rd | output | 1 | Read strobe, active high |
| wr | output | 1 | Write strobe, active high |
| halt | output | 1 | High once a stop instruction has been decoded |

## Verification
The embedded assertions check, on every clock, the properties that hold at all times:
- the phase counter advances by one per clock while running;
- once `halt` is high it stays high and the PC is frozen;
- `rd` and `wr` are never high together;
- every write strobe comes after a clock in which the bus was already driven;
- the accumulator changes only after a load-enable cycle.

Only the bench program can show that the operations compute the right values. It checks both outcomes of the skip, the jump target, the wrap of an addition, and a Fibonacci loop that ends through a skip on a counter. It does this by following the trace of fetch addresses and store cycles and then reading back the memory.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;
   typedef enum logic [2:0] {
      OP_HLT = 3'b000,
      OP_SKZ = 3'b001,
      OP_ADD = 3'b010,
      OP_AND = 3'b011,
      OP_XOR = 3'b100,
      OP_LDA = 3'b101,
      OP_STO = 3'b110,
      OP_JMP = 3'b111
   } opcode_t;

   localparam int OPC_W       = 3;
   // phase numbers inside one instruction slot
   localparam int PH_DECODE   = 2;
   localparam int PH_OPERAND  = 4;
   localparam int PH_DRIVE    = 5;
   localparam int PH_COMMIT   = 6;

   function automatic logic op_reads_mem(opcode_t op);
      return (op == OP_LDA) || (op == OP_ADD) || (op == OP_AND) || (op == OP_XOR);
   endfunction
endpackage

// File: rtl/acc_cpu_seq.sv
`timescale 1ns/1ps
module acc_cpu_seq #(
   parameter int PHASES = 8,
   localparam int PH_W  = $clog2(PHASES)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            stop_req,
   output logic [PH_W-1:0] phase,
   output logic            halted
);
   initial begin
      assert (PHASES == (1 << PH_W) && PHASES >= 8)
         else $error("PHASES must be a power of two and at least 8");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase  <= '0;
         halted <= 1'b0;
      end else begin
         if (!halted) phase <= phase + 1'b1;
         if (stop_req) halted <= 1'b1;
      end
   end

   // R2
   phase_step_chk: assert property (@(posedge clk) disable iff (rst)
      !halted |=> phase == PH_W'($past(phase) + 1'b1));
   // R8
   halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);
endmodule

// File: rtl/acc_cpu_pc.sv
`timescale 1ns/1ps
module acc_cpu_pc #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frozen,
   input  logic              step_one,
   input  logic              step_two,
   input  logic              load,
   input  logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] pc
);
   always_ff @(posedge clk) begin
      if (rst)           pc <= '0;
      else if (load)     pc <= target;
      else if (step_two) pc <= pc + ADDR_W'(2);
      else if (step_one) pc <= pc + ADDR_W'(1);
   end

   // R8
   pc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      frozen |=> $stable(pc));
endmodule

// File: rtl/acc_cpu_acc.sv
`timescale 1ns/1ps
module acc_cpu_acc
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  opcode_t           op,
   input  logic [DATA_W-1:0] mem_byte,
   output logic [DATA_W-1:0] acc,
   output logic              zero
);
   logic [DATA_W-1:0] result;

   always_comb begin
      case (op)
         OP_LDA:  result = mem_byte;
         OP_ADD:  result = acc + mem_byte;
         OP_AND:  result = acc & mem_byte;
         OP_XOR:  result = acc ^ mem_byte;
         default: result = acc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)       acc <= '0;
      else if (load) acc <= result;
   end

   assign zero = (acc == '0);

   // R4
   acc_update_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(acc) |-> $past(load));
endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8,
   parameter int PHASES = 8
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] addr,
   inout  wire  [DATA_W-1:0] data,
   output logic              rd,
   output logic              wr,
   output logic              halt
);
   localparam int IR_W     = OPC_W + ADDR_W;
   localparam int IR_BYTES = IR_W / DATA_W;
   localparam int PH_W     = $clog2(PHASES);

   initial begin
      assert (IR_W == IR_BYTES * DATA_W)
         else $error("opcode plus address must fill whole data bytes");
   end

   logic [PH_W-1:0]   phase;
   logic              halted;
   logic [IR_W-1:0]   ir;
   logic [ADDR_W-1:0] pc;
   logic [DATA_W-1:0] acc;
   logic              zero;
   opcode_t           op;
   logic [ADDR_W-1:0] operand;
   logic              fetch_half, stop_req, acc_load, drive_bus;
   logic              pc_inc, pc_skip, pc_jump;

   assign op      = opcode_t'(ir[IR_W-1 -: OPC_W]);
   assign operand = ir[ADDR_W-1:0];

   function automatic logic at(logic [PH_W-1:0] p, int n);
      return p == PH_W'(n);
   endfunction

   // instruction register: byte i is captured in phase i, high byte first
   for (genvar i = 0; i < IR_BYTES; i++) begin : g_ir_byte
      always_ff @(posedge clk) begin
         if (rst)
            ir[(IR_BYTES-i)*DATA_W-1 -: DATA_W] <= '0;
         else if (!halted && at(phase, i))
            ir[(IR_BYTES-i)*DATA_W-1 -: DATA_W] <= data;
      end
   end

   assign fetch_half = phase < PH_W'(PHASES / 2);
   assign stop_req   = !halted && at(phase, PH_DECODE) && op == OP_HLT;
   assign acc_load   = !halted && at(phase, PH_OPERAND) && op_reads_mem(op);
   assign drive_bus  = !halted && op == OP_STO &&
                       (at(phase, PH_DRIVE) || at(phase, PH_COMMIT));
   assign pc_inc     = !halted && phase < PH_W'(IR_BYTES);
   assign pc_skip    = !halted && at(phase, PH_COMMIT) && op == OP_SKZ && zero;
   assign pc_jump    = !halted && at(phase, PH_COMMIT) && op == OP_JMP;

   assign addr = fetch_half ? pc : operand;
   assign rd   = pc_inc || acc_load;
   assign wr   = drive_bus && at(phase, PH_COMMIT);
   assign halt = halted;
   assign data = drive_bus ? acc : 'z;

   acc_cpu_seq #(.PHASES(PHASES)) u_seq (
      .clk(clk), .rst(rst), .stop_req(stop_req), .phase(phase), .halted(halted)
   );

   acc_cpu_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk(clk), .rst(rst), .frozen(halted), .step_one(pc_inc),
      .step_two(pc_skip), .load(pc_jump), .target(operand), .pc(pc)
   );

   acc_cpu_acc #(.DATA_W(DATA_W)) u_acc (
      .clk(clk), .rst(rst), .load(acc_load), .op(op), .mem_byte(data),
      .acc(acc), .zero(zero)
   );

   // R9
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(rd && wr));
   // R5
   wr_setup_chk: assert property (@(posedge clk) disable iff (rst)
      wr |-> $past(drive_bus));
endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   wire  [7:0]  data;
   logic [12:0] addr;
   logic        rd, wr, halt;
   logic [7:0]  mem [0:1023];
   int          n_tests = 0, n_fail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   acc_cpu u_acc_cpu (.clk(clk), .rst(rst), .addr(addr), .data(data),
                      .rd(rd), .wr(wr), .halt(halt));

   assign data = rd ? mem[addr[9:0]] : 'z;
   always @(posedge clk) if (wr) mem[addr[9:0]] <= data;

   typedef struct packed {
      logic [12:0] pc;
      logic        sto;
      logic [12:0] waddr;
      logic [7:0]  wdata;
   } step_t;

   localparam int NSTEP = 11;
   localparam step_t TRACE [NSTEP] = '{
      '{13'h000, 1'b0, 13'h000, 8'h00},
      '{13'h002, 1'b0, 13'h000, 8'h00},
      '{13'h006, 1'b0, 13'h000, 8'h00},
      '{13'h008, 1'b0, 13'h000, 8'h00},
      '{13'h00A, 1'b0, 13'h000, 8'h00},
      '{13'h00C, 1'b0, 13'h000, 8'h00},
      '{13'h00E, 1'b1, 13'h202, 8'hF0},
      '{13'h010, 1'b0, 13'h000, 8'h00},
      '{13'h012, 1'b0, 13'h000, 8'h00},
      '{13'h014, 1'b1, 13'h205, 8'h00},
      '{13'h016, 1'b0, 13'h000, 8'h00}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input int a, input logic [2:0] op, input logic [12:0] opnd);
      mem[a]   = {op, opnd[12:8]};
      mem[a+1] = opnd[7:0];
   endtask

   task automatic load_program();
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      put('h000, 3'b101, 13'h200); put('h002, 3'b001, 13'h000);
      put('h004, 3'b000, 13'h000); put('h006, 3'b101, 13'h201);
      put('h008, 3'b001, 13'h000); put('h00A, 3'b011, 13'h203);
      put('h00C, 3'b100, 13'h201); put('h00E, 3'b110, 13'h202);
      put('h010, 3'b010, 13'h203); put('h012, 3'b010, 13'h204);
      put('h014, 3'b110, 13'h205); put('h016, 3'b111, 13'h01C);
      put('h018, 3'b000, 13'h000); put('h01A, 3'b000, 13'h000);
      put('h01C, 3'b101, 13'h210); put('h01E, 3'b010, 13'h211);
      put('h020, 3'b110, 13'h212); put('h022, 3'b101, 13'h211);
      put('h024, 3'b110, 13'h210); put('h026, 3'b101, 13'h212);
      put('h028, 3'b110, 13'h211); put('h02A, 3'b101, 13'h213);
      put('h02C, 3'b010, 13'h214); put('h02E, 3'b110, 13'h213);
      put('h030, 3'b001, 13'h000); put('h032, 3'b111, 13'h01C);
      put('h034, 3'b000, 13'h000);
      mem['h200] = 8'h00; mem['h201] = 8'hFF; mem['h203] = 8'h0F;
      mem['h204] = 8'h01; mem['h205] = 8'h77;
      mem['h210] = 8'h00; mem['h211] = 8'h01; mem['h213] = 8'h05;
      mem['h214] = 8'hFF;
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // called at the negedge inside phase 0; returns at phase 0 of the next instruction
   task automatic step(input step_t s, input string req);
      check(rd && addr == s.pc, req, addr, s.pc);
      repeat (6) @(negedge clk);
      if (s.sto) begin
         check(wr && addr == s.waddr, "R5 store strobe", addr, s.waddr);
         check(data == s.wdata, "R5 store data", data, s.wdata);
      end else begin
         check(!wr, "R5 no write outside store", wr, 0);
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int a, b, t, c;
      load_program();
      do_reset();
      // R1: first clock after reset fetches address 0
      check(rd && addr == 13'h000 && !halt, "R1 reset fetch", addr, 0);
      // R2 R3 R4 R6 R7: straight-line part of the trace
      for (int k = 0; k < NSTEP; k++) step(TRACE[k], "R3 fetch trace");
      // Fibonacci loop, ends through SKZ on the counter (R7 taken, R6 loop back)
      a = 0; b = 1; c = 5;
      for (int it = 0; it < 5; it++) begin
         t = (a + b) & 8'hFF;
         step('{13'h01C, 1'b0, 13'h0, 8'h0}, "R6 jump target");
         step('{13'h01E, 1'b0, 13'h0, 8'h0}, "R2 loop fetch");
         step('{13'h020, 1'b1, 13'h212, 8'(t)}, "R4 add result");
         step('{13'h022, 1'b0, 13'h0, 8'h0}, "R2 loop fetch");
         step('{13'h024, 1'b1, 13'h210, 8'(b)}, "R4 load result");
         step('{13'h026, 1'b0, 13'h0, 8'h0}, "R2 loop fetch");
         step('{13'h028, 1'b1, 13'h211, 8'(t)}, "R4 load result");
         step('{13'h02A, 1'b0, 13'h0, 8'h0}, "R2 loop fetch");
         step('{13'h02C, 1'b0, 13'h0, 8'h0}, "R2 loop fetch");
         c = c - 1;
         step('{13'h02E, 1'b1, 13'h213, 8'(c)}, "R4 add wrap");
         step('{13'h030, 1'b0, 13'h0, 8'h0}, "R7 skip fetch");
         a = b; b = t;
         if (it < 4) step('{13'h032, 1'b0, 13'h0, 8'h0}, "R7 no skip");
      end
      // R8: stop instruction at 0x034
      check(rd && addr == 13'h034, "R7 skip taken", addr, 13'h034);
      repeat (2) @(negedge clk);
      check(!halt, "R8 halt timing early", halt, 0);
      @(negedge clk);
      check(halt, "R8 halt raised", halt, 1);
      repeat (20) @(negedge clk);
      check(halt && !rd && !wr, "R8 halted quiet", {halt, rd, wr}, 3'b100);
      check(mem['h202] == 8'hF0, "R4 xor/and result", mem['h202], 8'hF0);
      check(mem['h205] == 8'h00, "R4 add wraps", mem['h205], 8'h00);
      check(mem['h210] == 8'd5, "R6 fib a", mem['h210], 5);
      check(mem['h211] == 8'd8, "R6 fib b", mem['h211], 8);
      check(mem['h213] == 8'd0, "R7 counter", mem['h213], 0);
      // R1: reset while halted restarts at 0
      do_reset();
      check(!halt && rd && addr == 13'h000, "R1 restart after halt", {halt, addr}, 0);
      step(TRACE[0], "R1 restart trace");
      // R1: reset in the middle of an instruction
      repeat (3) @(negedge clk);
      do_reset();
      check(rd && addr == 13'h000, "R1 mid-instruction reset", addr, 0);
      step(TRACE[0], "R1 trace after reset");
      check(rd && addr == 13'h002, "R3 after mid reset", addr, 13'h002);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule